// File: doc/BRIEF.md
# Run-Time Configurable Convolutional Byte De-Interleaver

This block undoes convolutional byte interleaving in a cable-TV receive chain. It sits after frame synchronisation. A commutator deals the incoming bytes in turn over DEPTH paths. Path j holds each byte for (DEPTH-1-j)*INC visits to that path. The bytes that come out are back in their transmitted order, each tagged with a valid strobe.

A 3-bit configuration code picks one of five (block size, depth, increment) settings. One of them is a pass-through with no byte delay. A new code may be written at any time. It is held pending and replaces the running setting only on the next frame-start byte.

The block stays idle until the frame-lock input is high and a frame-start byte arrives. A restart (the first start, a configuration change, or recovery after lock loss) clears the path pointers. It also suppresses output until the full latency of DEPTH*(DEPTH-1)*INC accepted bytes has passed, so stale memory never reaches the output.

Top module: `conv_deinterleaver`

## Requirements
- R1: After reset `out_valid` is 0 and `out_data` is 0.
- R2: No byte is output before a byte arrives with `in_valid`, `in_sof` and `lock` all high. Bytes received before that are dropped.
- R3: Configuration codes map to (depth, increment) as 0:(1,1), 1:(4,51), 2:(6,34), 3:(17,6), 4:(12,17). Code 0 is a bypass: each accepted byte appears on `out_data` with `out_valid` one clock later.
- R4: Number the accepted bytes k from a restart, and let path j = k mod DEPTH. The output produced by byte k is the input byte k-(DEPTH-1-j)*INC*DEPTH.
- R5: `out_valid` is high only in the clock after an accepted input byte. A cycle with `in_valid` low gives `out_valid` low in the next clock.
- R6: After a restart, the first DEPTH*(DEPTH-1)*INC accepted bytes produce no `out_valid`. Every later byte produces one.
- R7: A write with `cfg_wr` high stores `cfg_sel` as pending. The running setting is used until the next frame-start byte, which restarts the block with the pending setting.
- R8: A write of a code above 4 is ignored. The running stream continues across later frame starts without a restart.
- R9: While `lock` is low, no output is produced and the block stops. It resumes only at a frame-start byte with `lock` high, and then waits the full latency again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock | input | 1 | Frame synchronisation achieved |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration code (0..4) |
| in_valid | input | 1 | Input byte strobe |
| in_sof | input | 1 | Input byte is first of a frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | De-interleaved byte |

## Verification
Every setting is driven with a byte stream in which each value is a distinct function of its position. A byte taken from the wrong path, or with a delay that is off by even one visit, therefore shows up as a wrong value. Idle gaps at several spacings show that the paths advance on accepted bytes and not on clock cycles. Writes made in the middle of a frame, with both valid and illegal codes, separate "apply at the next frame start" from "apply at once" and from "ignore". A drop of lock followed by a restart shows that the warm-up latency is enforced again.

// File: rtl/conv_deinterleaver.sv
module conv_deinterleaver #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_sel,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int MEM_WORDS = 1122;
  localparam int AW   = $clog2(MEM_WORDS);
  localparam int DMAX = 17;
  localparam int PIW  = $clog2(DMAX);
  localparam int LW   = 8;
  localparam int CW   = 12;

  typedef struct packed {
    logic [PIW:0]  dep;
    logic [5:0]    inc;
    logic [LW-1:0] len0;
    logic [CW-1:0] lat;
  } cfg_t;

  function automatic cfg_t decode(input logic [2:0] s);
    case (s)
      3'd1:    decode = '{dep: 6'd4,  inc: 6'd51, len0: 8'd153, lat: 12'd612};
      3'd2:    decode = '{dep: 6'd6,  inc: 6'd34, len0: 8'd170, lat: 12'd1020};
      3'd3:    decode = '{dep: 6'd17, inc: 6'd6,  len0: 8'd96,  lat: 12'd1632};
      3'd4:    decode = '{dep: 6'd12, inc: 6'd17, len0: 8'd187, lat: 12'd2244};
      default: decode = '{dep: 6'd1,  inc: 6'd1,  len0: 8'd0,   lat: 12'd0};
    endcase
  endfunction

  logic [DW-1:0]  mem [MEM_WORDS];
  logic [LW-1:0]  ptr [DMAX];
  logic           running, pend;
  logic [2:0]     act_sel, pend_sel;
  logic [PIW-1:0] path;
  logic [AW-1:0]  base;
  logic [LW-1:0]  len;
  logic [CW-1:0]  cnt;

  logic           restart, go, align;
  logic [2:0]     sel_e;
  cfg_t           cfg_e;
  logic [PIW-1:0] path_e;
  logic [AW-1:0]  base_e, addr;
  logic [LW-1:0]  len_e, ptr_e;
  logic [CW-1:0]  cnt_e;
  logic           last_path;

  assign restart   = in_valid & in_sof & lock & (~running | pend);
  assign go        = in_valid & lock & (running | restart);
  assign align     = restart | in_sof;
  assign sel_e     = restart ? (pend ? pend_sel : act_sel) : act_sel;
  assign cfg_e     = decode(sel_e);
  assign path_e    = align ? '0 : path;
  assign base_e    = align ? '0 : base;
  assign len_e     = align ? cfg_e.len0 : len;
  assign ptr_e     = restart ? '0 : ptr[path_e];
  assign cnt_e     = restart ? '0 : cnt;
  assign addr      = base_e + AW'(ptr_e);
  assign last_path = ({1'b0, path_e} == cfg_e.dep - 1'b1);

  always_ff @(posedge clk) begin
    if (go && len_e != '0) mem[addr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      pend      <= 1'b0;
      act_sel   <= '0;
      pend_sel  <= '0;
      path      <= '0;
      base      <= '0;
      len       <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int i = 0; i < DMAX; i++) ptr[i] <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!lock) running <= 1'b0;
      if (restart) begin
        running <= 1'b1;
        act_sel <= sel_e;
        pend    <= 1'b0;
        for (int i = 0; i < DMAX; i++) ptr[i] <= '0;
      end
      if (go) begin
        out_valid <= (cnt_e >= cfg_e.lat);
        cnt       <= (cnt_e >= cfg_e.lat) ? cnt_e : cnt_e + 1'b1;
        if (len_e == '0) out_data <= in_data;
        else begin
          out_data     <= mem[addr];
          ptr[path_e]  <= (ptr_e == len_e - 1'b1) ? '0 : ptr_e + 1'b1;
        end
        if (last_path) begin
          path <= '0;
          base <= '0;
          len  <= cfg_e.len0;
        end else begin
          path <= path_e + 1'b1;
          base <= base_e + AW'(len_e);
          len  <= len_e - LW'(cfg_e.inc);
        end
      end
      if (cfg_wr && cfg_sel <= 3'd4) begin
        pend     <= 1'b1;
        pend_sel <= cfg_sel;
      end
    end
  end

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_no_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> !out_valid);

  assert_warmup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && cfg_e.lat != '0) |=> !out_valid);

  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && lock && in_valid && !in_sof && act_sel == 3'd0)
      |=> (out_valid && out_data == $past(in_data)));

  assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && len_e != '0) |-> (32'(addr) < MEM_WORDS));

  assert_bad_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel > 3'd4 && !restart)
      |=> (pend == $past(pend) && pend_sel == $past(pend_sel)));
endmodule

// File: tb/tb_conv_deinterleaver.sv
module tb_conv_deinterleaver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic [7:0] out_data;

  int checks = 0, failures = 0;
  bit done = 0;
  int D, INC, LAT, seg = 0, ci = 0;

  always #5 clk = ~clk;

  conv_deinterleaver dut (.*);

  // columns: code, frames, idle gap spacing (0 = none), code written late in the run
  localparam int VEC [6][4] = '{
    '{0, 2, 0, 1},
    '{1, 4, 5, 2},
    '{2, 6, 0, 7},
    '{2, 2, 3, 3},
    '{3, 9, 0, 4},
    '{4, 12, 7, 1}
  };

  function automatic logic [7:0] val(input int s, input int i);
    return 8'((i * 37 + (i >> 8) * 5 + s * 91) & 255);
  endfunction

  task automatic set_cfg(input int code);
    case (code)
      1: begin D = 4;  INC = 51; end
      2: begin D = 6;  INC = 34; end
      3: begin D = 17; INC = 6;  end
      4: begin D = 12; INC = 17; end
      default: begin D = 1; INC = 1; end
    endcase
    LAT = D * (D - 1) * INC;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit sof, input logic [7:0] d, input bit wr, input int code);
    @(negedge clk);
    in_valid = v; in_sof = sof; in_data = d; cfg_wr = wr; cfg_sel = 3'(code);
    @(posedge clk);
    #1;
    in_valid = 0; in_sof = 0; cfg_wr = 0;
  endtask

  task automatic run_seg(input int code, input int frames, input int gap, input int nxt, input bit cont);
    int n, wr_at;
    string req;
    if (!cont) begin set_cfg(code); seg++; ci = 0; end
    n = frames * 204;
    wr_at = n - 50;
    for (int k = 0; k < n; k++) begin
      if (gap != 0 && k % gap == gap - 1) begin
        cyc(0, 0, 8'h00, 0, 0);
        chk(out_valid == 0, "R5 idle", out_valid, 0);
      end
      cyc(1, ci % 204 == 0, val(seg, ci), k == wr_at, nxt);
      req = cont ? "R8" : (k > wr_at ? "R7" : (D == 1 ? "R3" : "R4"));
      chk(out_valid == (ci >= LAT), "R6 valid", out_valid, ci >= LAT);
      if (ci >= LAT) begin
        int j = ci % D;
        logic [7:0] e = val(seg, ci - (D - 1 - j) * INC * D);
        chk(out_data == e, req, out_data, e);
      end
      ci++;
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 0 && out_data == 0, "R1 reset", {out_valid, out_data}, 0);
    @(negedge clk) rst_n = 1;
    cyc(0, 0, 0, 1, 0);
    for (int k = 0; k < 5; k++) begin
      cyc(1, 1, 8'(k), 0, 0);
      chk(out_valid == 0, "R2 no lock", out_valid, 0);
    end
    lock = 1;
    for (int k = 0; k < 5; k++) begin
      cyc(1, 0, 8'(k), 0, 0);
      chk(out_valid == 0, "R2 no sof", out_valid, 0);
    end
    for (int v = 0; v < 6; v++)
      run_seg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], v > 0 && VEC[v-1][3] == 7);
    @(negedge clk) lock = 0;
    for (int k = 0; k < 10; k++) begin
      cyc(1, k == 3, 8'(k), 0, 0);
      chk(out_valid == 0, "R9 lock low", out_valid, 0);
    end
    @(negedge clk) lock = 1;
    for (int k = 0; k < 5; k++) begin
      cyc(1, 0, 8'(k), 0, 0);
      chk(out_valid == 0, "R9 wait sof", out_valid, 0);
    end
    run_seg(1, 4, 0, 7, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule